// File: doc/BRIEF.md
# Rotating-Window Block Transfer Sequencer

This engine belongs to one requester of a shared memory. The shared memory is split into interleaved banks, and a bank's index is the low bits of the word address. A rotation phase decides which bank each requester can reach on each clock. On every clock the window of a requester moves forward by one bank. When the engine gets a start pulse it moves one aligned block of words, one word per bank, between the shared memory and the requester's local register file. The direction input selects shared-to-local or local-to-shared. The engine does not wait for bank 0. After a fixed setup period it starts on whatever bank its window shows. It then takes one word per clock in rotation order, and the bank index wraps back to 0 after the last bank.

Each word lands at the local offset equal to its bank index. The latency is therefore the same for every starting phase: the setup clocks plus one clock per bank. The requester stays stalled on `busy_o` for that whole time. A one-clock `done_o` pulse marks the last clock of the transfer.

Top module: `rw_burst_seq`

## Requirements
- R1: After reset, with no start pulse, `busy_o`, `done_o`, `mem_req_o`, `loc_we_o` and `loc_re_o` are all low.
- R2: `busy_o` is high in the clock where a start is accepted and in the 17 clocks that follow, 18 clocks in all. It is low in the clock after that unless a new start arrives there.
- R3: In the start clock and the clock after it (the two setup clocks), `mem_req_o` is low. It is high in each of the 16 clocks after them (clocks 2 to 17 counted from the start clock), and never while idle.
- R4: In clock 2 the bank used is (phase_i + REQ_ID) mod 16, with phase_i sampled in that clock. Each later clock uses the previous bank plus one, wrapping 15 to 0, so the 16 banks are each used once.
- R5: `mem_addr_o` is the shared base captured at start with its low 4 bits replaced by the bank. The low 4 bits of `shared_base_i` have no effect.
- R6: `loc_addr_o` is the local base captured at start with its low 4 bits replaced by the bank. The low 4 bits of `local_base_i` have no effect.
- R7: With `dir_wr_i`=0 (read), each transfer clock has `mem_we_o`=0 and `loc_we_o`=1, and `loc_wdata_o` equals `mem_rdata_i` of that clock, so local offset k receives shared word k.
- R8: With `dir_wr_i`=1 (write), each transfer clock has `mem_we_o`=1, `loc_re_o`=1, `mem_be_o` all ones, and `mem_wdata_o` equal to `loc_rdata_i` of that clock.
- R9: `done_o` is high for exactly one clock, the 18th clock of each transfer, while `busy_o` is high.
- R10: A start pulse that arrives while a transfer is in progress is ignored. The transfer in progress keeps its addresses and direction, and no second transfer follows.
- R11: A start pulse in the clock right after the `done_o` clock is accepted, so two transfers can run back to back with `busy_o` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one block transfer |
| dir_wr_i | input | 1 | 0: shared to local, 1: local to shared |
| shared_base_i | input | SHARED_AW | Shared word address of the block (low bits ignored) |
| local_base_i | input | LOCAL_AW | Local word address of the block (low bits ignored) |
| phase_i | input | log2(NUM_BANKS) | Rotation phase of the shared memory |
| busy_o | output | 1 | Stall for the requester while a transfer runs |
| done_o | output | 1 | Last clock of a transfer |
| mem_req_o | output | 1 | Shared memory access this clock |
| mem_we_o | output | 1 | Shared memory write |
| mem_be_o | output | DATA_W/8 | Shared memory byte enables |
| mem_addr_o | output | SHARED_AW | Shared memory word address |
| mem_wdata_o | output | DATA_W | Shared memory write data |
| mem_rdata_i | input | DATA_W | Shared memory read data, valid in the same clock |
| loc_we_o | output | 1 | Local file write |
| loc_re_o | output | 1 | Local file read |
| loc_addr_o | output | LOCAL_AW | Local file word address |
| loc_wdata_o | output | DATA_W | Local file write data |
| loc_rdata_i | input | DATA_W | Local file read data, valid in the same clock |

## Verification
The bench builds the block with 16 banks, 32-bit words, a 12-bit shared address, a 9-bit local address, two setup clocks and requester index 5, with the aligned local addressing variant. The phase runs freely, so transfers start at several different phases and most bursts wrap past bank 15 at a different point. The non-zero requester index shows that the window offset is added to the phase. Nonzero low base bits, a start pulse in the middle of a burst, and a start in the clock right after `done_o` cover the ignore and back-to-back cases.

// File: rtl/rw_burst_pkg.sv
package rw_burst_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SETUP = 2'd1,
      SEQ_XFER  = 2'd2
   } seq_state_e;

   typedef enum logic {
      XDIR_TO_LOCAL  = 1'b0,
      XDIR_TO_SHARED = 1'b1
   } xfer_dir_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rw_burst_ctrl.sv
module rw_burst_ctrl
   import rw_burst_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned SETUP_CYC = 2,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
   localparam int unsigned SETUP_W  = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              accept_o,
   output logic              busy_o,
   output logic              xfer_o,
   output logic [BANK_W-1:0] beat_o,
   output logic              last_o
);

   localparam logic [BANK_W-1:0]  LAST_BEAT  = BANK_W'(NUM_BANKS - 1);
   localparam logic [SETUP_W-1:0] SETUP_LAST = SETUP_W'(SETUP_CYC - 1);

   seq_state_e         state_q, state_d;
   logic [SETUP_W-1:0] scnt_q, scnt_d;
   logic [BANK_W-1:0]  beat_q, beat_d;

   assign accept_o = start_i && (state_q == SEQ_IDLE);
   assign busy_o   = (state_q != SEQ_IDLE) || start_i;
   assign xfer_o   = (state_q == SEQ_XFER);
   assign beat_o   = beat_q;
   assign last_o   = xfer_o && (beat_q == LAST_BEAT);

   always_comb begin
      state_d = state_q;
      scnt_d  = scnt_q;
      beat_d  = beat_q;
      unique case (state_q)
         SEQ_IDLE: begin
            if (accept_o) begin
               beat_d = '0;
               if (SETUP_CYC <= 1) begin
                  state_d = SEQ_XFER;
               end else begin
                  state_d = SEQ_SETUP;
                  scnt_d  = SETUP_W'(1);
               end
            end
         end
         SEQ_SETUP: begin
            if (scnt_q == SETUP_LAST) begin
               state_d = SEQ_XFER;
               beat_d  = '0;
            end else begin
               scnt_d = scnt_q + SETUP_W'(1);
            end
         end
         SEQ_XFER: begin
            if (beat_q == LAST_BEAT) begin
               state_d = SEQ_IDLE;
               beat_d  = '0;
            end else begin
               beat_d = beat_q + BANK_W'(1);
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         scnt_q  <= '0;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         scnt_q  <= scnt_d;
         beat_q  <= beat_d;
      end
   end

endmodule

// File: rtl/rw_window_track.sv
module rw_window_track #(
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned REQ_ID    = 0,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_i,
   input  logic [BANK_W-1:0] beat_i,
   input  logic [BANK_W-1:0] phase_i,
   output logic [BANK_W-1:0] bank_o
);

   localparam logic [BANK_W-1:0] SLOT_OFS = BANK_W'(REQ_ID % NUM_BANKS);

   logic [BANK_W-1:0] window;
   logic [BANK_W-1:0] anchor_q;
   logic              first_beat;

   assign window     = phase_i + SLOT_OFS;
   assign first_beat = xfer_i && (beat_i == '0);
   assign bank_o     = first_beat ? window : (anchor_q + beat_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         anchor_q <= '0;
      end else if (first_beat) begin
         anchor_q <= window;
      end
   end

endmodule

// File: rtl/rw_addr_gen.sv
module rw_addr_gen #(
   parameter int unsigned SHARED_AW   = 16,
   parameter int unsigned LOCAL_AW    = 9,
   parameter int unsigned BANK_W      = 4,
   parameter bit          LOCAL_ALIGN = 1'b1
) (
   input  logic [SHARED_AW-1:0] shared_base_i,
   input  logic [LOCAL_AW-1:0]  local_base_i,
   input  logic [BANK_W-1:0]    bank_i,
   output logic [SHARED_AW-1:0] shared_addr_o,
   output logic [LOCAL_AW-1:0]  local_addr_o
);

   logic unused_shared_low;
   assign unused_shared_low = ^shared_base_i[BANK_W-1:0];
   assign shared_addr_o     = {shared_base_i[SHARED_AW-1:BANK_W], bank_i};

   generate
      if (LOCAL_ALIGN) begin : g_local_replace
         logic unused_local_low;
         assign unused_local_low = ^local_base_i[BANK_W-1:0];
         assign local_addr_o     = {local_base_i[LOCAL_AW-1:BANK_W], bank_i};
      end else begin : g_local_offset
         assign local_addr_o = local_base_i + LOCAL_AW'(bank_i);
      end
   endgenerate

endmodule

// File: rtl/rw_burst_seq.sv
module rw_burst_seq
   import rw_burst_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_BANKS   = 16,
   parameter int unsigned SHARED_AW   = 16,
   parameter int unsigned LOCAL_AW    = 9,
   parameter int unsigned SETUP_CYC   = 2,
   parameter int unsigned REQ_ID      = 0,
   parameter bit          LOCAL_ALIGN = 1'b1,
   localparam int unsigned BANK_W     = $clog2(NUM_BANKS),
   localparam int unsigned BE_W       = DATA_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 dir_wr_i,
   input  logic [SHARED_AW-1:0] shared_base_i,
   input  logic [LOCAL_AW-1:0]  local_base_i,
   input  logic [BANK_W-1:0]    phase_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 mem_req_o,
   output logic                 mem_we_o,
   output logic [BE_W-1:0]      mem_be_o,
   output logic [SHARED_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0]    mem_wdata_o,
   input  logic [DATA_W-1:0]    mem_rdata_i,
   output logic                 loc_we_o,
   output logic                 loc_re_o,
   output logic [LOCAL_AW-1:0]  loc_addr_o,
   output logic [DATA_W-1:0]    loc_wdata_o,
   input  logic [DATA_W-1:0]    loc_rdata_i
);

   // elaboration-time parameter checks
   if (!is_pow2(NUM_BANKS)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two and at least 2");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (SHARED_AW <= BANK_W || LOCAL_AW <= BANK_W) begin : g_bad_aw
      $error("address widths must exceed the bank index width");
   end

   logic              accept;
   logic              xfer;
   logic              last;
   logic [BANK_W-1:0] beat;
   logic [BANK_W-1:0] bank;

   xfer_dir_e            dir_q;
   logic [SHARED_AW-1:0] sbase_q;
   logic [LOCAL_AW-1:0]  lbase_q;
   logic [SHARED_AW-1:0] saddr;
   logic [LOCAL_AW-1:0]  laddr;

   rw_burst_ctrl #(
      .NUM_BANKS (NUM_BANKS),
      .SETUP_CYC (SETUP_CYC)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy_o),
      .xfer_o   (xfer),
      .beat_o   (beat),
      .last_o   (last)
   );

   rw_window_track #(
      .NUM_BANKS (NUM_BANKS),
      .REQ_ID    (REQ_ID)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .xfer_i  (xfer),
      .beat_i  (beat),
      .phase_i (phase_i),
      .bank_o  (bank)
   );

   rw_addr_gen #(
      .SHARED_AW   (SHARED_AW),
      .LOCAL_AW    (LOCAL_AW),
      .BANK_W      (BANK_W),
      .LOCAL_ALIGN (LOCAL_ALIGN)
   ) u_addr (
      .shared_base_i (sbase_q),
      .local_base_i  (lbase_q),
      .bank_i        (bank),
      .shared_addr_o (saddr),
      .local_addr_o  (laddr)
   );

   // request capture: only an accepted start loads the operands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= XDIR_TO_LOCAL;
         sbase_q <= '0;
         lbase_q <= '0;
      end else if (accept) begin
         dir_q   <= xfer_dir_e'(dir_wr_i);
         sbase_q <= shared_base_i;
         lbase_q <= local_base_i;
      end
   end

   // port steering by direction
   always_comb begin
      mem_req_o   = xfer;
      mem_we_o    = 1'b0;
      mem_be_o    = '0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      loc_we_o    = 1'b0;
      loc_re_o    = 1'b0;
      loc_addr_o  = '0;
      loc_wdata_o = '0;
      if (xfer) begin
         mem_addr_o = saddr;
         loc_addr_o = laddr;
         if (dir_q == XDIR_TO_SHARED) begin
            mem_we_o    = 1'b1;
            mem_be_o    = '1;
            loc_re_o    = 1'b1;
            mem_wdata_o = loc_rdata_i;
         end else begin
            loc_we_o    = 1'b1;
            loc_wdata_o = mem_rdata_i;
         end
      end
   end

   assign done_o = last;

endmodule

// File: rtl/rw_burst_seq_chk.sv
module rw_burst_seq_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned SHARED_AW = 16,
   parameter int unsigned LOCAL_AW  = 9,
   parameter int unsigned SETUP_CYC = 2,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
   localparam int unsigned BE_W     = DATA_W / 8,
   localparam int unsigned SPAN     = SETUP_CYC + NUM_BANKS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy_o,
   input logic                 done_o,
   input logic                 mem_req_o,
   input logic                 mem_we_o,
   input logic [BE_W-1:0]      mem_be_o,
   input logic [SHARED_AW-1:0] mem_addr_o,
   input logic [DATA_W-1:0]    mem_wdata_o,
   input logic [DATA_W-1:0]    mem_rdata_i,
   input logic                 loc_we_o,
   input logic                 loc_re_o,
   input logic [LOCAL_AW-1:0]  loc_addr_o,
   input logic [DATA_W-1:0]    loc_wdata_o,
   input logic [DATA_W-1:0]    loc_rdata_i
);

   // busy-length counter, restarted by each done pulse
   logic [$clog2(SPAN+1)-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (done_o) run_q <= '0;
      else if (busy_o) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !loc_we_o && !loc_re_o));

   p_busy_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (run_q < ($bits(run_q))'(SPAN)));

   p_done_at_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && run_q == ($bits(run_q))'(SPAN - 1)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_bank_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && $past(mem_req_o)) |->
         (mem_addr_o[BANK_W-1:0] == BANK_W'($past(mem_addr_o[BANK_W-1:0]) + 1'b1)));

   p_base_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o[SHARED_AW-1:BANK_W]));

   p_local_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (loc_addr_o[BANK_W-1:0] == mem_addr_o[BANK_W-1:0]));

   p_read_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o) |-> (loc_we_o && loc_wdata_o == mem_rdata_i));

   p_write_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |->
         (loc_re_o && !loc_we_o && (&mem_be_o) && mem_wdata_o == loc_rdata_i));

endmodule

bind rw_burst_seq rw_burst_seq_chk #(
   .DATA_W    (DATA_W),
   .NUM_BANKS (NUM_BANKS),
   .SHARED_AW (SHARED_AW),
   .LOCAL_AW  (LOCAL_AW),
   .SETUP_CYC (SETUP_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_be_o    (mem_be_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_rdata_i (mem_rdata_i),
   .loc_we_o    (loc_we_o),
   .loc_re_o    (loc_re_o),
   .loc_addr_o  (loc_addr_o),
   .loc_wdata_o (loc_wdata_o),
   .loc_rdata_i (loc_rdata_i)
);

// File: tb/rw_burst_seq_bench.sv
module rw_burst_seq_bench;

   localparam int CLK_P  = 10;
   localparam int SAW    = 12;
   localparam int LAW    = 9;
   localparam int DW     = 32;
   localparam int NB     = 16;
   localparam int ID     = 5;
   localparam int SPAN   = 18;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           dir_wr = 1'b0;
   logic [SAW-1:0] sbase = '0;
   logic [LAW-1:0] lbase = '0;
   logic [3:0]     phase = 4'd0;
   logic           busy, done, mem_req, mem_we, loc_we, loc_re;
   logic [3:0]     mem_be;
   logic [SAW-1:0] mem_addr;
   logic [LAW-1:0] loc_addr;
   logic [DW-1:0]  mem_wdata, mem_rdata, loc_wdata, loc_rdata;

   logic [DW-1:0] shm     [0:(1<<SAW)-1];
   logic [DW-1:0] lcl     [0:(1<<LAW)-1];
   logic [DW-1:0] ref_shm [0:(1<<SAW)-1];
   logic [DW-1:0] ref_lcl [0:(1<<LAW)-1];

   int checks = 0;
   int errors = 0;
   int done_seen = 0;
   int exp_done_cnt = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   rw_burst_seq #(
      .DATA_W (DW), .NUM_BANKS (NB), .SHARED_AW (SAW), .LOCAL_AW (LAW),
      .SETUP_CYC (2), .REQ_ID (ID), .LOCAL_ALIGN (1'b1)
   ) u_rw_burst_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start), .dir_wr_i (dir_wr),
      .shared_base_i (sbase), .local_base_i (lbase), .phase_i (phase),
      .busy_o (busy), .done_o (done), .mem_req_o (mem_req), .mem_we_o (mem_we),
      .mem_be_o (mem_be), .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
      .mem_rdata_i (mem_rdata), .loc_we_o (loc_we), .loc_re_o (loc_re),
      .loc_addr_o (loc_addr), .loc_wdata_o (loc_wdata), .loc_rdata_i (loc_rdata)
   );

   assign mem_rdata = shm[mem_addr];
   assign loc_rdata = lcl[loc_addr];

   always @(posedge clk) begin
      phase <= phase + 4'd1;
      if (mem_req && mem_we) shm[mem_addr] <= mem_wdata;
      if (loc_we) lcl[loc_addr] <= loc_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: cycle index since accepted start, -1 when idle
   int r_cnt = -1;
   bit r_dir;
   int r_sb, r_lb, r_first;

   always @(negedge clk) begin
      if (rst_n) begin
         int k, bank, ea, el;
         bit eb, ed, er;
         if (r_cnt < 0 && start) begin
            r_cnt = 0; r_dir = dir_wr; r_sb = int'(sbase); r_lb = int'(lbase);
            exp_done_cnt++;
         end
         eb = (r_cnt >= 0);
         ed = (r_cnt == SPAN - 1);
         er = (r_cnt >= 2);
         if (done) done_seen++;
         chk(busy == eb, "R2 busy", 32'(busy), 32'(eb));
         chk(done == ed, "R9 done", 32'(done), 32'(ed));
         chk(mem_req == er, "R3 mem_req", 32'(mem_req), 32'(er));
         if (er) begin
            k = r_cnt - 2;
            if (k == 0) r_first = (int'(phase) + ID) % NB;
            bank = (r_first + k) % NB;
            ea = (r_sb & ~(NB - 1)) | bank;
            el = (r_lb & ~(NB - 1)) | bank;
            chk(mem_addr == SAW'(ea), "R4/R5 mem_addr", 32'(mem_addr), 32'(ea));
            chk(loc_addr == LAW'(el), "R6 loc_addr", 32'(loc_addr), 32'(el));
            if (r_dir) begin
               chk(mem_we && loc_re && !loc_we, "R8 write strobes",
                   {29'd0, mem_we, loc_re, loc_we}, 32'h6);
               chk(mem_be == 4'hF, "R8 byte enables", 32'(mem_be), 32'hF);
               chk(mem_wdata == ref_lcl[el], "R8 write data", mem_wdata, ref_lcl[el]);
               ref_shm[ea] = ref_lcl[el];
            end else begin
               chk(!mem_we && loc_we, "R7 read strobes",
                   {30'd0, mem_we, loc_we}, 32'h1);
               chk(loc_wdata == ref_shm[ea], "R7 read data", loc_wdata, ref_shm[ea]);
               ref_lcl[el] = ref_shm[ea];
            end
         end
         if (r_cnt >= 0) begin
            r_cnt++;
            if (r_cnt == SPAN) r_cnt = -1;
         end
      end
   end

   task automatic do_start(input bit wr, input logic [SAW-1:0] sb, input logic [LAW-1:0] lb);
      @(posedge clk); #1;
      start = 1'b1; dir_wr = wr; sbase = sb; lbase = lb;
      @(posedge clk); #1;
      start = 1'b0; dir_wr = 1'b0; sbase = '0; lbase = '0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      summary();
   end

   initial begin
      for (int i = 0; i < (1 << SAW); i++) begin
         shm[i] = 32'hA000_0000 + 32'(i); ref_shm[i] = 32'hA000_0000 + 32'(i);
      end
      for (int i = 0; i < (1 << LAW); i++) begin
         lcl[i] = 32'h5000_0000 + 32'(i * 3); ref_lcl[i] = 32'h5000_0000 + 32'(i * 3);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      chk(!busy && !done && !mem_req && !loc_we && !loc_re, "R1 reset state",
          {27'd0, busy, done, mem_req, loc_we, loc_re}, 32'd0);
      // read burst, aligned bases
      do_start(1'b0, 12'h120, 9'h040);
      repeat (20) @(posedge clk);
      // read burst with nonzero low base bits (R5, R6), different phase
      repeat (3) @(posedge clk);
      do_start(1'b0, 12'h37B, 9'h085);
      repeat (21) @(posedge clk);
      // write burst from local block filled above (R8)
      repeat (7) @(posedge clk);
      do_start(1'b1, 12'h200, 9'h040);
      repeat (20) @(posedge clk);
      // R10: start in the middle of a burst is ignored
      do_start(1'b1, 12'h300, 9'h080);
      repeat (4) @(posedge clk);
      do_start(1'b0, 12'h500, 9'h1C0);
      repeat (18) @(posedge clk);
      for (int i = 0; i < NB; i++) begin
         chk(lcl[9'h1C0 + i] == 32'h5000_0000 + 32'((9'h1C0 + i) * 3),
             "R10 ignored start left local block", lcl[9'h1C0 + i],
             32'h5000_0000 + 32'((9'h1C0 + i) * 3));
      end
      // R11: second start in the clock after done
      do_start(1'b0, 12'h400, 9'h100);
      repeat (16) @(posedge clk);
      do_start(1'b1, 12'h600, 9'h100);
      repeat (22) @(posedge clk);
      @(negedge clk);
      chk(done_seen == exp_done_cnt && exp_done_cnt == 6, "R11/R9 done count",
          32'(done_seen), 32'(6));
      begin
         int bad_s, bad_l;
         bad_s = 0; bad_l = 0;
         for (int i = 0; i < (1 << SAW); i++) if (shm[i] !== ref_shm[i]) bad_s++;
         for (int i = 0; i < (1 << LAW); i++) if (lcl[i] !== ref_lcl[i]) bad_l++;
         chk(bad_s == 0, "R8 shared memory image", 32'(bad_s), 32'd0);
         chk(bad_l == 0, "R7 local file image", 32'(bad_l), 32'd0);
      end
      summary();
   end

endmodule